// File: doc/BRIEF.md
# Security-zoned retention register bank

This block is a bank of 32 retained 32-bit words on a simple request/response bus. Every request carries a secure or non-secure attribute. Two border indices, held in a configuration word, split the bank into three zones. Words below the first border are fully secure. Words between the borders can be read by anyone but written only by secure requests. Words at or above the second border are open to both kinds of request.

Each request is checked against the zone of the word it addresses. A request that is not allowed is blocked, and an error bit is raised in its response. Only secure requests can move the borders. A tamper input wipes every word of the bank in one cycle and leaves the borders as they are.

Top module: `zoned_retention_bank`

## Requirements
- R1: Word i sits at byte offset 4*i, for i from 0 to 31, and address bits [1:0] are ignored. Every request gets a response one cycle later: `rsp_valid_o` is high in that cycle, and it is low in a cycle that follows no request. A write response returns zero data.
- R2: After reset every word reads as zero. The configuration word at byte offset 0x80 reads 0x0000_0F0A: the first border (B1) is in bits [4:0] with value 10, the second border (B2) is in bits [12:8] with value 15, and all other bits read zero.
- R3: Word i is fully secure when i < B1. It is secure-write/non-secure-read when B1 <= i < B2. It is non-secure when i >= B2.
- R4: A secure request can read and write any word, whatever its zone.
- R5: A non-secure read of a fully secure word returns zero with `rsp_err_o`=1. A non-secure read of any other word returns its contents with `rsp_err_o`=0.
- R6: A non-secure write to a fully secure or secure-write word is dropped, and its response has `rsp_err_o`=1. A non-secure write to a non-secure word is stored without error.
- R7: Only a secure write changes the configuration word. A non-secure write to it is dropped with `rsp_err_o`=1. Either kind of request can read it without error.
- R8: If a configuration write carries B2 < B1, B2 is stored equal to the written B1.
- R9: While `tamper_i` is high, all 32 words become zero at the next edge, and a write to a word in the same cycle is lost. A word read sampled in that cycle returns zero. The borders are unchanged by tamper.
- R10: A write followed in the next cycle by a read of the same word returns the newly written value.
- R11: A request to byte offsets 0x84 to 0xFF responds with `rsp_err_o`=1 and zero data, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_i | input | 1 | Wipe request for the whole bank |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Secure attribute of the request |
| req_addr_i | input | 8 | Byte address within the block |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_err_o | output | 1 | Request was blocked or unmapped |
| rsp_rdata_o | output | 32 | Read data, zero on error or write |

## Verification
The bench first runs directed cases. These cover each side of both borders under reset values and after a border move, a clamped configuration write, a non-secure write to the configuration word, tamper colliding with a write and with a read, and unmapped offsets. Each case separates a zone decode that is off by one from one that is correct. A long seeded random mix of attributes, offsets with stray low bits, sporadic border changes and sporadic tamper then runs against a reference model of the bank. This random mix exposes filtering that depends on the wrong attribute or the wrong border.

// File: rtl/zrb_pkg.sv
package zrb_pkg;
    // zone codes used inside the block
    typedef enum logic [1:0] {
        ZONE_SEC  = 2'd0,
        ZONE_SWNR = 2'd1,
        ZONE_OPEN = 2'd2
    } zone_e;

    // filter verdict for one request
    typedef struct packed {
        logic reg_wr;
        logic reg_rd;
        logic cfg_wr;
        logic cfg_rd;
        logic deny;
    } verdict_t;
endpackage

// File: rtl/zrb_zone_map.sv
module zrb_zone_map #(
    parameter int unsigned NREG = 32,
    parameter int unsigned BW   = 5
) (
    input  logic [BW-1:0]   b1_i,
    input  logic [BW-1:0]   b2_i,
    output logic [NREG-1:0] sec_o,
    output logic [NREG-1:0] ro_o
);
    localparam int unsigned CW = BW + 1;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic below_b1;
        logic below_b2;
        assign below_b1 = ({1'b0, b1_i} > CW'(g));
        assign below_b2 = ({1'b0, b2_i} > CW'(g));
        assign sec_o[g] = below_b1;
        assign ro_o[g]  = !below_b1 && below_b2;
    end
endmodule

// File: rtl/zrb_access_check.sv
module zrb_access_check
    import zrb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid_i,
    input  logic     write_i,
    input  logic     secure_i,
    input  logic     is_reg_i,
    input  logic     is_cfg_i,
    input  logic     zone_sec_i,
    input  logic     zone_ro_i,
    output verdict_t verdict_o
);
    zone_e zone;

    always_comb begin
        if (zone_sec_i)     zone = ZONE_SEC;
        else if (zone_ro_i) zone = ZONE_SWNR;
        else                zone = ZONE_OPEN;
    end

    always_comb begin
        verdict_o = '0;
        if (valid_i) begin
            if (!is_reg_i && !is_cfg_i) begin
                verdict_o.deny = 1'b1;
            end else if (is_cfg_i) begin
                if (!write_i)      verdict_o.cfg_rd = 1'b1;
                else if (secure_i) verdict_o.cfg_wr = 1'b1;
                else               verdict_o.deny   = 1'b1;
            end else if (secure_i) begin
                if (write_i) verdict_o.reg_wr = 1'b1;
                else         verdict_o.reg_rd = 1'b1;
            end else if (write_i) begin
                if (zone == ZONE_OPEN) verdict_o.reg_wr = 1'b1;
                else                   verdict_o.deny   = 1'b1;
            end else begin
                if (zone == ZONE_SEC) verdict_o.deny   = 1'b1;
                else                  verdict_o.reg_rd = 1'b1;
            end
        end
    end

    // at most one action per request, and exactly one when a request is present
    p_single_action_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> $countones(verdict_o) == 1);
    p_idle_no_action_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> verdict_o == '0);
    // a secure request to a mapped slot is never refused
    p_secure_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && secure_i && (is_reg_i || is_cfg_i) |-> !verdict_o.deny);
    // no non-secure write ever reaches the borders
    p_cfg_secure_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_o.cfg_wr |-> secure_i);
endmodule

// File: rtl/zrb_border_cfg.sv
module zrb_border_cfg #(
    parameter int unsigned BW     = 5,
    parameter int unsigned RST_B1 = 10,
    parameter int unsigned RST_B2 = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [BW-1:0] wb1_i,
    input  logic [BW-1:0] wb2_i,
    output logic [BW-1:0] b1_o,
    output logic [BW-1:0] b2_o
);
    typedef struct packed {
        logic [BW-1:0] b1;
        logic [BW-1:0] b2;
    } border_t;

    border_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d.b1 = wb1_i;
            cfg_d.b2 = (wb2_i < wb1_i) ? wb1_i : wb2_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.b1 <= BW'(RST_B1);
            cfg_q.b2 <= BW'(RST_B2);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign b1_o = cfg_q.b1;
    assign b2_o = cfg_q.b2;

    p_border_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.b1 <= cfg_q.b2);
    p_border_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_q));
endmodule

// File: rtl/zoned_retention_bank.sv
module zoned_retention_bank
    import zrb_pkg::*;
#(
    parameter int unsigned NREG   = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned RST_B1 = 10,
    parameter int unsigned RST_B2 = 15,
    parameter int unsigned B2_LSB = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tamper_i,
    input  logic                       req_valid_i,
    input  logic                       req_write_i,
    input  logic                       req_secure_i,
    input  logic [$clog2(NREG)+2:0]    req_addr_i,
    input  logic [DW-1:0]              req_wdata_i,
    output logic                       rsp_valid_o,
    output logic                       rsp_err_o,
    output logic [DW-1:0]              rsp_rdata_o
);
    localparam int unsigned IDX_W  = $clog2(NREG);
    localparam int unsigned BW     = IDX_W;
    localparam int unsigned SLOT_W = IDX_W + 1;
    localparam int unsigned ADDR_W = SLOT_W + 2;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    rsp_valid;
        logic                    rsp_err;
        logic [DW-1:0]           rdata;
    } bank_t;

    bank_t st_d, st_q;

    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  idx;
    logic              is_reg, is_cfg;
    logic [BW-1:0]     b1, b2;
    logic [NREG-1:0]   sec_vec, ro_vec;
    verdict_t          verdict;
    logic [DW-1:0]     cfg_word;
    logic              unused_addr_lo;

    assign slot           = req_addr_i[ADDR_W-1:2];
    assign idx            = slot[IDX_W-1:0];
    assign is_reg         = (slot < SLOT_W'(NREG));
    assign is_cfg         = (slot == SLOT_W'(NREG));
    assign unused_addr_lo = ^req_addr_i[1:0];

    zrb_zone_map #(.NREG(NREG), .BW(BW)) u_zone_map (
        .b1_i  (b1),
        .b2_i  (b2),
        .sec_o (sec_vec),
        .ro_o  (ro_vec)
    );

    zrb_access_check u_access_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (req_valid_i),
        .write_i    (req_write_i),
        .secure_i   (req_secure_i),
        .is_reg_i   (is_reg),
        .is_cfg_i   (is_cfg),
        .zone_sec_i (sec_vec[idx]),
        .zone_ro_i  (ro_vec[idx]),
        .verdict_o  (verdict)
    );

    zrb_border_cfg #(.BW(BW), .RST_B1(RST_B1), .RST_B2(RST_B2)) u_border_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (verdict.cfg_wr),
        .wb1_i   (req_wdata_i[BW-1:0]),
        .wb2_i   (req_wdata_i[B2_LSB +: BW]),
        .b1_o    (b1),
        .b2_o    (b2)
    );

    always_comb begin
        cfg_word              = '0;
        cfg_word[BW-1:0]      = b1;
        cfg_word[B2_LSB +: BW] = b2;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid_i;
        st_d.rsp_err   = verdict.deny;
        st_d.rdata     = '0;
        if (verdict.reg_rd && !tamper_i) st_d.rdata = st_q.regs[idx];
        if (verdict.cfg_rd)              st_d.rdata = cfg_word;
        if (verdict.reg_wr)              st_d.regs[idx] = req_wdata_i;
        if (tamper_i)                    st_d.regs = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_err_o   = st_q.rsp_err;
    assign rsp_rdata_o = st_q.rdata;

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    p_no_rsp_unasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    p_err_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> rsp_valid_o && rsp_rdata_o == '0);
    p_tamper_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_i |=> st_q.regs == '0);
    p_tamper_keeps_border_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_i && !(req_valid_i && req_write_i && is_cfg) |=> $stable({b1, b2}));
    p_ns_guarded_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_write_i && !req_secure_i && is_reg &&
        (sec_vec[idx] || ro_vec[idx]) |=> st_q.regs == $past(st_q.regs) || $past(tamper_i));
    p_unmapped_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !is_reg && !is_cfg && !tamper_i |=>
        st_q.regs == $past(st_q.regs) && rsp_err_o);
endmodule

// File: tb/sim_zoned_retention_bank.sv
module sim_zoned_retention_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tamper = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] mem [32];
    int          mb1, mb2;

    always #(CLK_PERIOD/2) clk = ~clk;

    zoned_retention_bank u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tamper_i     (tamper),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_secure_i (req_secure),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .rsp_valid_o  (rsp_valid),
        .rsp_err_o    (rsp_err),
        .rsp_rdata_o  (rsp_rdata)
    );

    function automatic int zone_of(int i);
        if (i < mb1) return 0;
        if (i < mb2) return 1;
        return 2;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle(string tag);
        req_valid = 1'b0; tamper = 1'b0;
        @(negedge clk);
        check(tag, "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic do_req(bit w, bit s, logic [7:0] a, logic [31:0] wd, bit t, string tag);
        int          slot;
        bit          isr, isc, e_err, do_w, do_c;
        logic [31:0] e_rd;
        int          nb1, nb2;
        slot = int'(a[7:2]);
        isr  = slot < 32;
        isc  = slot == 32;
        e_err = 0; do_w = 0; do_c = 0; e_rd = '0;
        if (!isr && !isc) e_err = 1;
        else if (isc) begin
            if (!w) e_rd = (32'(mb2) << 8) | 32'(mb1);
            else if (s) do_c = 1;
            else e_err = 1;
        end else if (w) begin
            if (s || zone_of(slot) == 2) do_w = 1;
            else e_err = 1;
        end else begin
            if (s || zone_of(slot) != 0) e_rd = t ? 32'd0 : mem[slot];
            else e_err = 1;
        end
        req_valid = 1'b1; req_write = w; req_secure = s;
        req_addr = a; req_wdata = wd; tamper = t;
        @(negedge clk);
        check(tag, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(tag, "rsp_err", {31'b0, rsp_err}, {31'b0, e_err});
        check(tag, "rsp_rdata", rsp_rdata, e_rd);
        req_valid = 1'b0; tamper = 1'b0;
        if (do_w && !t) mem[slot] = wd;
        if (do_c) begin
            nb1 = int'(wd[4:0]); nb2 = int'(wd[12:8]);
            if (nb2 < nb1) nb2 = nb1;
            mb1 = nb1; mb2 = nb2;
        end
        if (t) for (int i = 0; i < 32; i++) mem[i] = '0;
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0D0C);
        for (int i = 0; i < 32; i++) mem[i] = '0;
        mb1 = 10; mb2 = 15;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        idle("R1");
        do_req(0, 1, 8'h80, 0, 0, "R2");
        do_req(0, 1, 8'h00, 0, 0, "R2");
        do_req(0, 1, 8'h7C, 0, 0, "R2");
        // R4 / R10 secure write then immediate read
        do_req(1, 1, 8'h0C, 32'hA5A5_5A5A, 0, "R4");
        do_req(0, 1, 8'h0C, 0, 0, "R10");
        do_req(1, 0, 8'h50, 32'h1357_9BDF, 0, "R6");
        do_req(0, 0, 8'h50, 0, 0, "R10");
        // R5 / R3 border B1
        do_req(0, 0, 8'h0C, 0, 0, "R5");
        do_req(1, 1, 8'h24, 32'h0000_0099, 0, "R4");
        do_req(0, 0, 8'h24, 0, 0, "R3");
        do_req(1, 1, 8'h28, 32'h0000_00AA, 0, "R4");
        do_req(0, 0, 8'h28, 0, 0, "R3");
        // R6 / R3 border B2
        do_req(1, 0, 8'h30, 32'hDEAD_BEEF, 0, "R6");
        do_req(0, 1, 8'h30, 0, 0, "R6");
        do_req(1, 0, 8'h38, 32'h1111_1111, 0, "R3");
        do_req(1, 0, 8'h3C, 32'h2222_2222, 0, "R3");
        do_req(0, 1, 8'h38, 0, 0, "R3");
        do_req(0, 1, 8'h3C, 0, 0, "R3");
        // R7 config protection, low address bits ignored (R1)
        do_req(1, 0, 8'h80, 32'h0000_1F00, 0, "R7");
        do_req(0, 0, 8'h83, 0, 0, "R7");
        // R8 clamp
        do_req(1, 1, 8'h80, 32'h0000_0514, 0, "R8");
        do_req(0, 1, 8'h80, 0, 0, "R8");
        do_req(0, 0, 8'h4C, 0, 0, "R3");
        do_req(1, 0, 8'h50, 32'h0BAD_F00D, 0, "R3");
        do_req(0, 0, 8'h51, 0, 0, "R1");
        // R9 tamper over a write and over a read
        do_req(1, 1, 8'h64, 32'hCAFE_0001, 1, "R9");
        do_req(0, 1, 8'h64, 0, 0, "R9");
        do_req(0, 1, 8'h50, 0, 0, "R9");
        do_req(0, 1, 8'h80, 0, 0, "R9");
        do_req(1, 1, 8'h54, 32'h7777_0000, 0, "R4");
        do_req(0, 1, 8'h54, 0, 1, "R9");
        do_req(0, 1, 8'h54, 0, 0, "R9");
        // R11 unmapped
        do_req(1, 1, 8'h84, 32'hFFFF_FFFF, 0, "R11");
        do_req(0, 1, 8'hFC, 0, 0, "R11");
        idle("R1");
        // seeded random mix
        for (int k = 0; k < 4000; k++) begin
            int          r, slot;
            bit          w, s, t;
            logic [7:0]  a;
            logic [31:0] wd;
            string       tag;
            r = int'($urandom % 100);
            if (r < 4) begin
                idle("R1");
            end else begin
                if (r < 8) a = 8'h80;
                else a = 8'((($urandom % 36) << 2) | ($urandom % 4));
                w  = 1'($urandom % 2);
                s  = 1'($urandom % 2);
                t  = ($urandom % 64) == 0;
                wd = $urandom;
                if (r < 8) wd = {19'b0, 5'($urandom), 3'b0, 5'($urandom)};
                slot = int'(a[7:2]);
                if (t) tag = "R9";
                else if (slot > 32) tag = "R11";
                else if (slot == 32) tag = w ? "R8" : "R7";
                else if (s) tag = "R4";
                else if (w) tag = "R6";
                else tag = "R5";
                do_req(w, s, a, wd, t, tag);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule